// File: doc/BRIEF.md
# Multiplexed Boot ROM Read Sequencer

This block turns a single-byte read request from the host side of the chip into an access to an external boot ROM. The ROM is reached over a narrow interface: an 8-bit shared address/data bus, two dedicated low address lines and an active-low chip enable. The ROM space is 256 KB, so byte addresses are 18 bits wide.

An accepted request goes through a fixed sequence. Two address cycles come first, with chip enable high. In the first, the shared bus carries address bits 9..2 and the select line is low, which opens the low external latch. In the second, the bus carries bits 17..10 and the select line is high, which closes the low latch and opens the high one. In the data phase chip enable is low and the bus is released. The select line then carries address bit 1, and the dedicated line carries bit 0 throughout. After a parameterised number of wait cycles the returned byte is sampled and reported with a one-cycle valid pulse.

The request side is valid/ready. The block raises `req_ready` only when idle. A request offered while a sequence is running is held off until the block returns to idle, so the requester must hold `req_valid` and `req_addr` until it sees the handshake. The response side is a plain valid pulse with no back-pressure. The consumer must take `rsp_data` in the cycle `rsp_valid` is high. `WAIT_CYC` must lie between 1 and 15.

Top module: `bootrom_rd_seq`

## Requirements
- R1: While reset is asserted and in the idle state after it, `rom_ce_n` is 1, `rom_ad_oe` is 0, `rom_a1` and `rom_a0` are 0, `rsp_valid` is 0 and `req_ready` is 1. An asynchronous reset during a sequence returns the block to this state at once.
- R2: A request is taken on a rising edge where `req_valid` and `req_ready` are both 1. `req_ready` is 1 only in idle. A request offered while busy is held off and is served once the block is idle, not dropped. Changes to `req_addr` while busy do not affect the sequence in progress.
- R3: In the cycle after acceptance, the following hold:
  - `rom_ad_oe` is 1 and `rom_ad_o` equals address bits 9..2.
  - `rom_a1` is 0, which selects the low latch.
  - `rom_a0` equals address bit 0 and `rom_ce_n` is 1.
- R4: In the next cycle, the following hold:
  - `rom_ad_oe` is 1 and `rom_ad_o` equals address bits 17..10.
  - `rom_a1` is 1, which selects the high latch.
  - `rom_ce_n` is 1.
- R5: For exactly `WAIT_CYC` cycles after that, `rom_ce_n` is 0, `rom_ad_oe` is 0, `rom_a1` equals address bit 1 and `rom_a0` equals address bit 0.
- R6: `rom_ad_i` is sampled on the edge that ends the last data-phase cycle. `rsp_data` holds that byte while `rsp_valid` is high for exactly one cycle, 2+`WAIT_CYC` cycles after the accepting edge. `rsp_data` changes only when a new byte is reported.
- R7: `rom_ce_n` is 1 in the `rsp_valid` cycle. The bus is never driven while `rom_ce_n` is 0.
- R8: A request accepted in the `rsp_valid` cycle starts its first address cycle immediately, with no idle gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Block idle and able to take a request |
| req_addr | input | 18 | Byte address of the read |
| rsp_valid | output | 1 | One-cycle pulse: `rsp_data` holds the byte read |
| rsp_data | output | 8 | Byte returned by the ROM |
| rom_a0 | output | 1 | Address bit 0 |
| rom_a1 | output | 1 | Latch select in address cycles, address bit 1 in data phase |
| rom_ad_o | output | 8 | Shared bus output value |
| rom_ad_oe | output | 1 | Shared bus output enable (pad drives when 1) |
| rom_ad_i | input | 8 | Shared bus input value from the pad |
| rom_ce_n | output | 1 | ROM chip enable, active low |

## Verification
The hardest case to reach from the ports is a request that arrives while a sequence is running. The requester must be held off, and its address must change mid-sequence without disturbing the read in progress. The bench raises `req_valid` with a different address during the second address cycle and keeps it up. It checks that `req_ready` stays low and that the data-phase address lines still follow the first address. The held request must then be taken in the response cycle with no gap. The bench also models the two external latches and a ROM whose byte is valid only after `WAIT_CYC` cycles of chip enable. A shortened wait, a wrong latch select or a swapped address byte therefore shows up as a wrong `rsp_data`.

// File: rtl/bootrom_seq_pkg.sv
package bootrom_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ALO  = 2'd1,
    ST_AHI  = 2'd2,
    ST_DATA = 2'd3
  } seq_state_e;
endpackage

// File: rtl/bootrom_wait_timer.sv
module bootrom_wait_timer #(
  parameter int WAIT_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic last
);
  localparam int CNT_W = (WAIT_CYC < 2) ? 1 : $clog2(WAIT_CYC);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= CNT_W'(WAIT_CYC - 1);
    end else if (run && cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign last = run && (cnt == '0);
endmodule

// File: rtl/bootrom_bus_drive.sv
module bootrom_bus_drive
  import bootrom_seq_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 + 2 * DATA_W
) (
  input  seq_state_e        st,
  input  logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe,
  output logic              a1,
  output logic              a0,
  output logic              ce_n
);
  localparam int LO_BASE = 2;
  localparam int HI_BASE = 2 + DATA_W;

  always_comb begin
    ad_o  = '0;
    ad_oe = 1'b0;
    a1    = 1'b0;
    a0    = 1'b0;
    ce_n  = 1'b1;
    unique case (st)
      ST_ALO: begin
        ad_o  = addr[LO_BASE +: DATA_W];
        ad_oe = 1'b1;
        a0    = addr[0];
      end
      ST_AHI: begin
        ad_o  = addr[HI_BASE +: DATA_W];
        ad_oe = 1'b1;
        a1    = 1'b1;
        a0    = addr[0];
      end
      ST_DATA: begin
        ce_n = 1'b0;
        a1   = addr[1];
        a0   = addr[0];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/bootrom_rd_seq.sv
module bootrom_rd_seq
  import bootrom_seq_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int WAIT_CYC = 3,
  localparam int ADDR_W  = 2 + 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rom_a0,
  output logic              rom_a1,
  output logic [DATA_W-1:0] rom_ad_o,
  output logic              rom_ad_oe,
  input  logic [DATA_W-1:0] rom_ad_i,
  output logic              rom_ce_n
);
  generate
    if (WAIT_CYC < 1 || WAIT_CYC > 15) begin : g_bad_wait
      $error("WAIT_CYC out of range 1..15");
    end
  endgenerate

  seq_state_e        st;
  logic [ADDR_W-1:0] addr_q;
  logic              wait_last;

  assign req_ready = (st == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      addr_q    <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (st)
        ST_IDLE: if (req_valid) begin
          addr_q <= req_addr;
          st     <= ST_ALO;
        end
        ST_ALO: st <= ST_AHI;
        ST_AHI: st <= ST_DATA;
        ST_DATA: if (wait_last) begin
          rsp_data  <= rom_ad_i;
          rsp_valid <= 1'b1;
          st        <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  bootrom_wait_timer #(.WAIT_CYC(WAIT_CYC)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .load (st == ST_AHI),
    .run  (st == ST_DATA),
    .last (wait_last)
  );

  bootrom_bus_drive #(.DATA_W(DATA_W)) u_drive (
    .st   (st),
    .addr (addr_q),
    .ad_o (rom_ad_o),
    .ad_oe(rom_ad_oe),
    .a1   (rom_a1),
    .a0   (rom_a0),
    .ce_n (rom_ce_n)
  );
endmodule

// File: rtl/bootrom_rd_seq_chk.sv
module bootrom_rd_seq_chk #(
  parameter int DATA_W   = 8,
  parameter int WAIT_CYC = 3,
  localparam int ADDR_W  = 2 + 2 * DATA_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_data,
  input logic              rom_a0,
  input logic              rom_a1,
  input logic [DATA_W-1:0] rom_ad_o,
  input logic              rom_ad_oe,
  input logic [DATA_W-1:0] rom_ad_i,
  input logic              rom_ce_n
);
  logic [4:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_cnt <= '0;
    else if (!rom_ce_n) low_cnt <= low_cnt + 1'b1;
    else low_cnt <= '0;
  end

  p_idle_lines_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_ce_n && !rom_ad_oe) |-> (!rom_a0 && !rom_a1));

  p_busy_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!rom_ce_n || rom_ad_oe) |-> !req_ready);

  p_first_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=>
      (rom_ad_oe && !rom_a1 && rom_ce_n &&
       rom_ad_o == $past(req_addr[2 +: DATA_W])));

  p_second_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_ad_oe && !rom_a1) |=>
      (rom_ad_oe && rom_a1 && rom_ce_n &&
       rom_ad_o == $past(req_addr[2 + DATA_W +: DATA_W], 2)));

  p_wait_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !rom_ce_n |-> (low_cnt < 5'(WAIT_CYC)));

  p_wait_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (!$past(rom_ce_n) && $past(low_cnt) == 5'(WAIT_CYC - 1)));

  p_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_sample_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_data == $past(rom_ad_i)));

  p_data_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rsp_data) |-> rsp_valid);

  p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rom_ad_oe |-> rom_ce_n);

  p_ce_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rom_ce_n);
endmodule

bind bootrom_rd_seq bootrom_rd_seq_chk #(.DATA_W(DATA_W), .WAIT_CYC(WAIT_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
  .rom_a0(rom_a0), .rom_a1(rom_a1), .rom_ad_o(rom_ad_o), .rom_ad_oe(rom_ad_oe),
  .rom_ad_i(rom_ad_i), .rom_ce_n(rom_ce_n)
);

// File: tb/sim_bootrom_rd_seq.sv
`timescale 1ns/1ps
module sim_bootrom_rd_seq;
  localparam int W = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [17:0] req_addr = '0;
  logic        rsp_valid;
  logic [7:0]  rsp_data;
  logic        rom_a0, rom_a1, rom_ad_oe, rom_ce_n;
  logic [7:0]  rom_ad_o, rom_ad_i;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  bootrom_rd_seq #(.DATA_W(8), .WAIT_CYC(W)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .rom_a0(rom_a0), .rom_a1(rom_a1), .rom_ad_o(rom_ad_o), .rom_ad_oe(rom_ad_oe),
    .rom_ad_i(rom_ad_i), .rom_ce_n(rom_ce_n)
  );

  // external latches and a ROM with access time of W cycles
  logic [7:0] lat_lo = '0, lat_hi = '0;
  int         acc = 0;

  function automatic logic [7:0] romf(input logic [17:0] a);
    return a[7:0] ^ a[15:8] ^ {4{a[17:16]}} ^ 8'h5A;
  endfunction

  always @(negedge clk) begin
    if (rom_ce_n && rom_ad_oe) begin
      if (!rom_a1) lat_lo <= rom_ad_o;
      else         lat_hi <= rom_ad_o;
    end
    if (!rom_ce_n) acc <= acc + 1;
    else           acc <= 0;
  end

  always_comb begin
    if (!rom_ce_n && acc >= W) rom_ad_i = romf({lat_hi, lat_lo, rom_a1, rom_a0});
    else                       rom_ad_i = 8'hEE;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [17:0] a);
    @(negedge clk);
    check("R2 ready in idle", 32'(req_ready), 1);
    check("R6 pulse ended", 32'(rsp_valid), 0);
    req_valid = 1'b1;
    req_addr  = a;
    @(posedge clk);
  endtask

  // follows one sequence accepted at the preceding posedge
  task automatic follow(input logic [17:0] a, input bit chain, input logic [17:0] na);
    @(negedge clk);
    req_valid = 1'b0;
    check("R3 oe",   32'(rom_ad_oe), 1);
    check("R3 bus",  32'(rom_ad_o), 32'(a[9:2]));
    check("R3 a1",   32'(rom_a1), 0);
    check("R3 a0",   32'(rom_a0), 32'(a[0]));
    check("R3 ce_n", 32'(rom_ce_n), 1);
    check("R2 busy", 32'(req_ready), 0);
    @(negedge clk);
    check("R4 oe",   32'(rom_ad_oe), 1);
    check("R4 bus",  32'(rom_ad_o), 32'(a[17:10]));
    check("R4 a1",   32'(rom_a1), 1);
    check("R4 ce_n", 32'(rom_ce_n), 1);
    if (chain) begin
      req_valid = 1'b1;
      req_addr  = na;
    end
    for (int i = 0; i < W; i++) begin
      @(negedge clk);
      check("R5 ce_n", 32'(rom_ce_n), 0);
      check("R5 oe",   32'(rom_ad_oe), 0);
      check("R5 a1",   32'(rom_a1), 32'(a[1]));
      check("R5 a0",   32'(rom_a0), 32'(a[0]));
      check("R6 no early valid", 32'(rsp_valid), 0);
      check("R2 held off", 32'(req_ready), 0);
    end
    @(negedge clk);
    check("R6 valid", 32'(rsp_valid), 1);
    check("R6 data",  32'(rsp_data), 32'(romf(a)));
    check("R7 ce_n released", 32'(rom_ce_n), 1);
    check("R2 ready again", 32'(req_ready), 1);
  endtask

  // stimulus table: {idle gap cycles, address}
  localparam logic [21:0] VEC [8] = '{
    {4'd0, 18'h00000}, {4'd2, 18'h3FFFF}, {4'd1, 18'h2AAAA}, {4'd0, 18'h15555},
    {4'd3, 18'h00003}, {4'd0, 18'h3FC00}, {4'd1, 18'h003FC}, {4'd0, 18'h1E2D1}
  };

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 ce_n",  32'(rom_ce_n), 1);
    check("R1 oe",    32'(rom_ad_oe), 0);
    check("R1 valid", 32'(rsp_valid), 0);
    check("R1 a1a0",  32'({rom_a1, rom_a0}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready after reset", 32'(req_ready), 1);

    // table walk
    for (int v = 0; v < 8; v++) begin
      issue(VEC[v][17:0]);
      follow(VEC[v][17:0], 1'b0, '0);
      repeat (int'(VEC[v][21:18])) @(negedge clk);
    end

    // R2/R8: request offered while busy, address changed mid-sequence,
    // taken in the response cycle with no idle gap
    issue(18'h2C3A5);
    follow(18'h2C3A5, 1'b1, 18'h01A7E);
    @(posedge clk);
    follow(18'h01A7E, 1'b0, '0);

    // R1: asynchronous reset in the data phase
    issue(18'h30F0F);
    repeat (3) @(negedge clk);
    check("R1 mid data phase", 32'(rom_ce_n), 0);
    rst_n = 1'b0;
    #1;
    check("R1 reset ce_n", 32'(rom_ce_n), 1);
    check("R1 reset ready", 32'(req_ready), 1);
    check("R1 reset oe", 32'(rom_ad_oe), 0);
    req_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 no response after reset", 32'(rsp_valid), 0);
    issue(18'h12345);
    follow(18'h12345, 1'b0, '0);

    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule